// File: doc/BRIEF.md
# AHB-Lite Address Decode and Response Steering Fabric

This block is the glue between a single bus master and a set of memory-mapped slaves. Each cycle it compares the master's address against a parameter-defined map and raises exactly one slave select line. When no region matches, it routes the transfer to a built-in fallback responder. The decoded choice is captured into a data-phase register only on edges where the bus is ready. That register steers the chosen slave's read data, ready and response back to the master. The same combined ready signal goes to the master and is also looped back to every slave as its ready input.

The fallback responder is a small state machine with three states. In `DS_OKAY` it answers with a zero-wait OKAY. It moves from `DS_OKAY` to `DS_ERR_WAIT` when an active transfer (NONSEQ or SEQ) to unmapped space is accepted. It always moves from `DS_ERR_WAIT` to `DS_ERR_LAST`. From `DS_ERR_LAST` it returns to `DS_ERR_WAIT` if another active unmapped transfer is accepted, and to `DS_OKAY` otherwise. This gives the two-cycle ERROR response.

When the slave count parameter is 1, the fabric reduces to plain wires. No decoding takes place in that case.

Top module: `ahbl_fabric`

## Requirements
- R1: `hsel[i]` is high when `(haddr & mask_i) == base_i`. At most one bit of `hsel` is high in any cycle. By default slave i owns the 4 KiB window starting at i*0x1000, and on overlap the lowest index wins.
- R2: An address matching no region drives `hsel` to all zeros and selects the internal fallback responder.
- R3: The data-phase select loads the decoded choice only on rising edges where `hready` is high. While `hready` is low, a changing address does not change which slave is steered.
- R4: `hrdata` and `hresp` come from the slave selected in the most recent address phase that was accepted with `hready` high.
- R5: `hready` equals the steered slave's `s_hreadyout`. This single signal serves both as the master's ready and as the ready input looped back to every slave.
- R6: After reset and before any data phase, `hready` is 1, `hresp` is 0 (OKAY) and `hrdata` is 0.
- R7: An accepted transfer with `htrans` = 2'b10 or 2'b11 to unmapped space gets a two-cycle ERROR response. In the first cycle `hready`=0 and `hresp`=1. In the second cycle `hready`=1 and `hresp`=1.
- R8: An accepted transfer with `htrans` = 2'b00 (IDLE) or 2'b01 (BUSY) to unmapped space gets a zero-wait OKAY: `hready`=1 and `hresp`=0.
- R9: While the fallback responder is steered, `hrdata` is 0.
- R10: With one slave, `hsel[0]` is always 1, and `hready`, `hresp` and `hrdata` are that slave's outputs passed straight through.
- R11: `hresetn` is active low and acts asynchronously. Asserting it mid-cycle clears the data-phase select and the fallback state at once, so `hready` reads 1 and `hresp` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock, rising edge |
| hresetn | input | 1 | Asynchronous reset, active low |
| haddr | input | AW | Address-phase address from the master |
| htrans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| hsel | output | NSLV | One-hot select per slave for the current address phase |
| hready | output | 1 | Combined ready, to the master and back to all slaves |
| hresp | output | 1 | Steered response: 0 OKAY, 1 ERROR |
| hrdata | output | DW | Steered read data |
| s_hrdata | input | NSLV*DW | Read data of all slaves, slave i at bits [i*DW +: DW] |
| s_hreadyout | input | NSLV | Per-slave ready output |
| s_hresp | input | NSLV | Per-slave response |

## Verification
The scoreboard runs back-to-back transfers across all three mapped windows. Each slave returns a distinct data word, so a swapped or stale steering path shows up as the wrong word. A wait state from one slave is held while the address moves to a different slave. This separates a select that loads only on ready edges from one that follows the address. Unmapped traffic is driven as active transfers, as IDLE/BUSY transfers, and as back-to-back active transfers. These three patterns separate the two-cycle ERROR path, the zero-wait OKAY path and re-entry into the error sequence from its second cycle. A mid-cycle reset during an error, and a one-slave instance, cover the asynchronous clear and the pass-through variant.

// File: rtl/ahbl_pkg.sv
package ahbl_pkg;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;

    typedef enum logic [1:0] {
        DS_OKAY,
        DS_ERR_WAIT,
        DS_ERR_LAST
    } dflt_st_e;

    localparam logic RESP_OKAY = 1'b0;
    localparam logic RESP_ERR  = 1'b1;

endpackage

// File: rtl/ahbl_addr_dec.sv
module ahbl_addr_dec #(
    parameter int NSLV = 3,
    parameter int AW   = 32,
    parameter logic [NSLV*AW-1:0] BASE = '0,
    parameter logic [NSLV*AW-1:0] MASK = '0
) (
    input  logic [AW-1:0]   haddr,
    output logic [NSLV-1:0] hit,
    output logic            miss
);

    // priority match: lowest index claims an overlapping address
    always_comb begin
        hit  = '0;
        miss = 1'b1;
        for (int i = 0; i < NSLV; i++) begin
            if (miss && ((haddr & MASK[i*AW +: AW]) == BASE[i*AW +: AW])) begin
                hit[i] = 1'b1;
                miss   = 1'b0;
            end
        end
    end

endmodule

// File: rtl/ahbl_dflt_slave.sv
module ahbl_dflt_slave
    import ahbl_pkg::*;
(
    input  logic       hclk,
    input  logic       hresetn,
    input  logic       sel,
    input  logic       hready,
    input  logic [1:0] htrans,
    output logic       readyout,
    output logic       resp
);

    dflt_st_e st, st_nx;
    logic     take;

    // only NONSEQ/SEQ (htrans[1]) accepted while ready start an error
    assign take = sel && hready && htrans[1];

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) st <= DS_OKAY;
        else          st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            DS_OKAY:     if (take) st_nx = DS_ERR_WAIT;
            DS_ERR_WAIT: st_nx = DS_ERR_LAST;
            DS_ERR_LAST: st_nx = take ? DS_ERR_WAIT : DS_OKAY;
            default:     st_nx = DS_OKAY;
        endcase
    end

    always_comb begin
        unique case (st)
            DS_ERR_WAIT: begin readyout = 1'b0; resp = RESP_ERR;  end
            DS_ERR_LAST: begin readyout = 1'b1; resp = RESP_ERR;  end
            default:     begin readyout = 1'b1; resp = RESP_OKAY; end
        endcase
    end

endmodule

// File: rtl/ahbl_resp_mux.sv
module ahbl_resp_mux #(
    parameter int NSLV = 3,
    parameter int DW   = 32
) (
    input  logic             hclk,
    input  logic             hresetn,
    input  logic [NSLV:0]    sel_ap,
    input  logic [NSLV*DW-1:0] s_hrdata,
    input  logic [NSLV-1:0]  s_hreadyout,
    input  logic [NSLV-1:0]  s_hresp,
    input  logic             dflt_ready,
    input  logic             dflt_resp,
    output logic             hready,
    output logic             hresp,
    output logic [DW-1:0]    hrdata,
    output logic [NSLV:0]    dp_sel
);

    // data-phase select: bit NSLV stands for the fallback responder
    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn)    dp_sel <= '0;
        else if (hready) dp_sel <= sel_ap;
    end

    always_comb begin
        hready = 1'b1;
        hresp  = 1'b0;
        hrdata = '0;
        if (dp_sel != '0) begin
            hready = 1'b0;
            for (int i = 0; i < NSLV; i++) begin
                if (dp_sel[i]) begin
                    hready = s_hreadyout[i];
                    hresp  = s_hresp[i];
                    hrdata = s_hrdata[i*DW +: DW];
                end
            end
            if (dp_sel[NSLV]) begin
                hready = dflt_ready;
                hresp  = dflt_resp;
            end
        end
    end

endmodule

// File: rtl/ahbl_fabric.sv
module ahbl_fabric #(
    parameter int NSLV = 3,
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter logic [NSLV*AW-1:0] SLV_BASE = {32'h0000_2000, 32'h0000_1000, 32'h0000_0000},
    parameter logic [NSLV*AW-1:0] SLV_MASK = {3{32'hFFFF_F000}}
) (
    input  logic               hclk,
    input  logic               hresetn,
    input  logic [AW-1:0]      haddr,
    input  logic [1:0]         htrans,
    output logic [NSLV-1:0]    hsel,
    output logic               hready,
    output logic               hresp,
    output logic [DW-1:0]      hrdata,
    input  logic [NSLV*DW-1:0] s_hrdata,
    input  logic [NSLV-1:0]    s_hreadyout,
    input  logic [NSLV-1:0]    s_hresp
);

    localparam int NSEL = NSLV + 1;

    logic [NSEL-1:0] dp_sel;

    generate
        if (NSLV == 1) begin : g_direct
            // one slave: no decode, no fallback, straight wires
            assign hsel   = 1'b1;
            assign hready = s_hreadyout[0];
            assign hresp  = s_hresp[0];
            assign hrdata = s_hrdata;
            assign dp_sel = NSEL'(1);
        end else begin : g_fabric
            logic [NSLV-1:0] hit;
            logic            miss;
            logic            dflt_ready, dflt_resp;

            ahbl_addr_dec #(
                .NSLV(NSLV), .AW(AW), .BASE(SLV_BASE), .MASK(SLV_MASK)
            ) u_dec (
                .haddr (haddr),
                .hit   (hit),
                .miss  (miss)
            );

            ahbl_dflt_slave u_dflt (
                .hclk     (hclk),
                .hresetn  (hresetn),
                .sel      (miss),
                .hready   (hready),
                .htrans   (htrans),
                .readyout (dflt_ready),
                .resp     (dflt_resp)
            );

            ahbl_resp_mux #(.NSLV(NSLV), .DW(DW)) u_mux (
                .hclk        (hclk),
                .hresetn     (hresetn),
                .sel_ap      ({miss, hit}),
                .s_hrdata    (s_hrdata),
                .s_hreadyout (s_hreadyout),
                .s_hresp     (s_hresp),
                .dflt_ready  (dflt_ready),
                .dflt_resp   (dflt_resp),
                .hready      (hready),
                .hresp       (hresp),
                .hrdata      (hrdata),
                .dp_sel      (dp_sel)
            );

            assign hsel = hit;
        end
    endgenerate

endmodule

// File: rtl/ahbl_fabric_chk.sv
module ahbl_fabric_chk #(
    parameter int NSLV = 3
) (
    input logic            hclk,
    input logic            hresetn,
    input logic [1:0]      htrans,
    input logic [NSLV-1:0] hsel,
    input logic            hready,
    input logic            hresp,
    input logic [NSLV-1:0] s_hreadyout,
    input logic [NSLV:0]   dp_sel
);

    a_r1_sel_onehot: assert property (@(posedge hclk) disable iff (!hresetn)
        $onehot0(hsel));

    a_r3_hold_on_wait: assert property (@(posedge hclk) disable iff (!hresetn)
        !hready |=> $stable(dp_sel));

    a_r5_ready_source: assert property (@(posedge hclk) disable iff (!hresetn)
        (hsel[0] && hready) |=> (hready == s_hreadyout[0]));

    a_r7_err_first: assert property (@(posedge hclk) disable iff (!hresetn)
        (hsel == '0 && hready && htrans[1]) |=> (!hready && hresp));

    a_r7_err_second: assert property (@(posedge hclk) disable iff (!hresetn)
        (dp_sel[NSLV] && !hready) |=> (hready && hresp));

    a_r8_idle_okay: assert property (@(posedge hclk) disable iff (!hresetn)
        (hsel == '0 && hready && !htrans[1]) |=> (hready && !hresp));

    always @(posedge hclk) begin
        if (!hresetn) begin
            a_r6_reset_idle: assert (hready && !hresp);
        end
    end

endmodule

bind ahbl_fabric ahbl_fabric_chk #(.NSLV(NSLV)) u_chk (
    .hclk        (hclk),
    .hresetn     (hresetn),
    .htrans      (htrans),
    .hsel        (hsel),
    .hready      (hready),
    .hresp       (hresp),
    .s_hreadyout (s_hreadyout),
    .dp_sel      (dp_sel)
);

// File: tb/sim_ahbl_fabric.sv
module sim_ahbl_fabric;

    logic        clk = 1'b0;
    logic        rstn = 1'b0;
    logic [31:0] haddr = 32'h0000_1000;
    logic [1:0]  htrans = 2'b00;
    logic [2:0]  s_rdy = 3'b111;
    logic [2:0]  s_rsp = 3'b000;
    logic [95:0] s_dat = {32'hC2C2_0002, 32'hB1B1_0001, 32'hA0A0_0000};
    logic [2:0]  hsel;
    logic        hready, hresp;
    logic [31:0] hrdata;

    logic        s1_rdy = 1'b1, s1_rsp = 1'b0;
    logic [31:0] s1_dat = 32'h1111_0000;
    logic [0:0]  u1_sel;
    logic        u1_rdy, u1_rsp;
    logic [31:0] u1_dat;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    ahbl_fabric u0 (
        .hclk(clk), .hresetn(rstn), .haddr(haddr), .htrans(htrans),
        .hsel(hsel), .hready(hready), .hresp(hresp), .hrdata(hrdata),
        .s_hrdata(s_dat), .s_hreadyout(s_rdy), .s_hresp(s_rsp)
    );

    ahbl_fabric #(.NSLV(1), .SLV_BASE(32'h0), .SLV_MASK(32'h0)) u1 (
        .hclk(clk), .hresetn(rstn), .haddr(haddr), .htrans(htrans),
        .hsel(u1_sel), .hready(u1_rdy), .hresp(u1_rsp), .hrdata(u1_dat),
        .s_hrdata(s1_dat), .s_hreadyout(s1_rdy), .s_hresp(s1_rsp)
    );

    typedef struct packed {
        logic [2:0]  sel;
        logic        rdy;
        logic        rsp;
        logic [31:0] dat;
    } exp_t;

    exp_t  q_exp[$];
    string q_tag[$];

    // reference state: -1 none, 0..2 slave, 3 fallback; ds 0 okay, 1 wait, 2 last
    int m_dp = -1;
    int m_ds = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int dec(input logic [31:0] a);
        for (int i = 0; i < 3; i++)
            if ((a & 32'hFFFF_F000) == 32'(i) * 32'h1000) return i;
        return 3;
    endfunction

    // driver: apply one address phase, push expectation, advance the model
    task automatic cyc(input logic [31:0] a, input logic [1:0] t, input string tag);
        int   d;
        exp_t e;
        logic take;
        haddr  = a;
        htrans = t;
        d      = dec(a);
        e.sel  = (d < 3) ? 3'(1 << d) : 3'b000;
        if (m_dp < 0) begin
            e.rdy = 1'b1; e.rsp = 1'b0; e.dat = '0;
        end else if (m_dp < 3) begin
            e.rdy = s_rdy[m_dp]; e.rsp = s_rsp[m_dp]; e.dat = s_dat[m_dp*32 +: 32];
        end else begin
            e.dat = '0;
            e.rdy = (m_ds != 1);
            e.rsp = (m_ds != 0);
        end
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(posedge clk);
        take = (d == 3) && e.rdy && t[1];
        case (m_ds)
            0:       m_ds = take ? 1 : 0;
            1:       m_ds = 2;
            default: m_ds = take ? 1 : 0;
        endcase
        if (e.rdy) m_dp = d;
        #1;
    endtask

    // monitor: compare queued expectations away from the rising edge
    always @(negedge clk) begin
        while (q_exp.size() > 0) begin
            exp_t  e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            chk({t, " hsel"},   {29'b0, hsel},   {29'b0, e.sel});
            chk({t, " hready"}, {31'b0, hready}, {31'b0, e.rdy});
            chk({t, " hresp"},  {31'b0, hresp},  {31'b0, e.rsp});
            chk({t, " hrdata"}, hrdata,          e.dat);
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk("R6 reset hready", {31'b0, hready}, 32'd1);
        chk("R6 reset hresp",  {31'b0, hresp},  32'd0);
        chk("R6 reset hrdata", hrdata,          32'd0);
        chk("R1 decode in reset", {29'b0, hsel}, 32'd2);
        rstn = 1'b1;

        cyc(32'h0000_0004, 2'b10, "R6");
        cyc(32'h0000_1000, 2'b10, "R4");
        s_rdy[1] = 1'b0;
        cyc(32'h0000_2000, 2'b10, "R5");
        cyc(32'h0000_2004, 2'b10, "R3");
        s_rdy[1] = 1'b1;
        cyc(32'h0000_2004, 2'b10, "R3");
        s_rsp[2] = 1'b1;
        cyc(32'h0000_9000, 2'b10, "R4");
        s_rsp[2] = 1'b0;
        cyc(32'h0000_9004, 2'b11, "R7");
        cyc(32'h0000_9004, 2'b00, "R7");
        cyc(32'h0000_A000, 2'b01, "R8");
        cyc(32'h0000_A000, 2'b10, "R9");
        cyc(32'h0000_0000, 2'b10, "R7");
        cyc(32'h0000_B000, 2'b10, "R7");
        cyc(32'h0000_0008, 2'b10, "R7");
        cyc(32'h0000_0008, 2'b10, "R7");
        s_dat[31:0] = 32'h5A5A_5A5A;
        cyc(32'h0000_1004, 2'b00, "R4");
        cyc(32'h0000_C000, 2'b10, "R2");

        // now in the first error cycle; reset asynchronously mid-cycle
        #1;
        chk("R7 error wait", {31'b0, hready}, 32'd0);
        rstn = 1'b0;
        #1;
        chk("R11 async hready", {31'b0, hready}, 32'd1);
        chk("R11 async hresp",  {31'b0, hresp},  32'd0);
        m_dp = -1;
        m_ds = 0;
        @(posedge clk);
        #1;
        rstn = 1'b1;
        cyc(32'h0000_2000, 2'b00, "R6");

        // single-slave pass-through
        s1_rdy = 1'b0; s1_rsp = 1'b1; s1_dat = 32'hDEAD_0001;
        #1;
        chk("R10 sel",    {31'b0, u1_sel}, 32'd1);
        chk("R10 hready", {31'b0, u1_rdy}, 32'd0);
        chk("R10 hresp",  {31'b0, u1_rsp}, 32'd1);
        chk("R10 hrdata", u1_dat, 32'hDEAD_0001);
        s1_rdy = 1'b1; s1_rsp = 1'b0; s1_dat = 32'h0BAD_F00D;
        #1;
        chk("R10 hready", {31'b0, u1_rdy}, 32'd1);
        chk("R10 hrdata", u1_dat, 32'h0BAD_F00D);

        @(posedge clk);
        #1;
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule